// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects event pulses from the transmit, receive and control logic of an Ethernet MAC into a 32-bit pending-event register. Next to it sits a 32-bit mask register. Software reads and writes both through a small register port. The block drives thirteen separate interrupt lines, one for each event cause. Each line is high while its pending bit and its mask bit are both set.

Only the thirteen high-order bits, 31 down to 19, hold state. Every lower bit reads as zero.

Software clears a pending bit by writing 1 to it. A write of any value to the transmit-control address raises the graceful-stop event right away.

The outputs are registered. The block keeps the previous active set, which is pending AND mask, and updates a line only when that line's own bit of the active set has changed.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the pending register, the mask register and all thirteen interrupt lines are zero.
- R2: A pulse on `evtSet[k]` sets pending bit 19+k. Reading address 0 returns the pending register. The bit-to-cause map is:
  - bit 31: heartbeat
  - bit 30: babbling receive
  - bit 29: babbling transmit
  - bit 28: graceful stop
  - bit 27: transmit frame
  - bit 26: transmit buffer
  - bit 25: receive frame
  - bit 24: receive buffer
  - bit 23: management interface
  - bit 22: bus error
  - bit 21: late collision
  - bit 20: retry limit
  - bit 19: underrun
- R3: A write to address 0 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: When a set pulse and a write-1-to-clear reach the same pending bit in the same cycle, the bit ends up set.
- R5: A write to address 1 loads the mask register, and a read of address 1 returns it. Bits 18 to 0 of both the pending and the mask register always read as zero.
- R6: `irqOut[k]` equals bit 19+k of (pending AND mask) as it stood one clock earlier. A change in pending or mask therefore reaches the line one cycle later.
- R7: A write of any data to address 2 (transmit control) sets pending bit 28, the graceful-stop event. Address 2 reads as zero.
- R8: Address 3 reads as zero. A write to address 3 changes neither the pending register nor the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 pending, 1 mask, 2 transmit control, 3 unused |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| evtSet | input | 13 | Event pulses; bit k sets pending bit 19+k |
| irqOut | output | 13 | Per-cause interrupt lines; bit k follows active bit 19+k |

## Verification
Each of the thirteen causes is raised on its own, with its mask first closed and then open. This separates a wrong bit position from a masking fault and from an off-by-one in the line latency. Mask patterns are then swept over a fixed pending set, and each line is compared with the arithmetic AND, so a line that follows the wrong operand shows up. A clear that lands in the same cycle as a set tells set-priority apart from clear-priority. Writes to the transmit-control address and to the unused address, each followed by readback, expose stray decode paths.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  parameter int DATA_W    = 32;
  parameter int NUM_LINES = 13;
  localparam int LOW_BIT  = DATA_W - NUM_LINES;
  localparam int GRA_BIT  = 28;
  localparam int ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PEND  = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_TXCTL = 2'd2,
    ADDR_NONE  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic wrPend;
    logic wrMask;
    logic wrTxCtl;
  } ctrlStrb_t;
endpackage

// File: rtl/evt_irq_ctrl_dec.sv
module evt_irq_ctrl_dec
  import evt_irq_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrb_t         strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      unique case (regAddr_e'(regAddr))
        ADDR_PEND:  strb.wrPend  = 1'b1;
        ADDR_MASK:  strb.wrMask  = 1'b1;
        ADDR_TXCTL: strb.wrTxCtl = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrb_t            strb,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [NUM_LINES-1:0] evtSet,
  output logic [DATA_W-1:0]    regRdData,
  output logic [DATA_W-1:0]    pendQ,
  output logic [DATA_W-1:0]    maskQ,
  output logic [NUM_LINES-1:0] irqOut
);
  logic [NUM_LINES-1:0] activeNow;

  assign pendQ[LOW_BIT-1:0] = '0;
  assign maskQ[LOW_BIT-1:0] = '0;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_bit
    localparam int BIT = LOW_BIT + k;
    logic setHit;
    logic clrHit;

    assign setHit = evtSet[k] | (strb.wrTxCtl & (BIT == GRA_BIT));
    assign clrHit = strb.wrPend & regWrData[BIT];
    assign activeNow[k] = pendQ[BIT] & maskQ[BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pendQ[BIT] <= 1'b0;
        maskQ[BIT] <= 1'b0;
        irqOut[k]  <= 1'b0;
      end else begin
        // set has priority over the write-1-to-clear
        if (setHit)      pendQ[BIT] <= 1'b1;
        else if (clrHit) pendQ[BIT] <= 1'b0;
        if (strb.wrMask) maskQ[BIT] <= regWrData[BIT];
        // a line moves only when its own active bit differs
        if (activeNow[k] != irqOut[k]) irqOut[k] <= activeNow[k];
      end
    end
  end

  always_comb begin
    unique case (regAddr_e'(regAddr))
      ADDR_PEND: regRdData = pendQ;
      ADDR_MASK: regRdData = maskQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_LINES-1:0] evtSet,
  output logic [NUM_LINES-1:0] irqOut
);
  ctrlStrb_t         strb;
  logic [DATA_W-1:0] pendQ;
  logic [DATA_W-1:0] maskQ;

  evt_irq_ctrl_dec u_dec (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  evt_irq_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .evtSet    (evtSet),
    .regRdData (regRdData),
    .pendQ     (pendQ),
    .maskQ     (maskQ),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
  import evt_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [NUM_LINES-1:0] evtSet,
  input logic [DATA_W-1:0]    pendQ,
  input logic [DATA_W-1:0]    maskQ,
  input logic [NUM_LINES-1:0] irqOut
);
  assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evtSet) |=> ((pendQ[DATA_W-1:LOW_BIT] & $past(evtSet)) == $past(evtSet)));

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == 2'd0) |=>
      ((pendQ[DATA_W-1:LOW_BIT] & $past(regWrData[DATA_W-1:LOW_BIT] & ~evtSet)) == '0));

  assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ[LOW_BIT-1:0] == '0) && (maskQ[LOW_BIT-1:0] == '0));

  assert_line_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irqOut == $past(pendQ[DATA_W-1:LOW_BIT] & maskQ[DATA_W-1:LOW_BIT])));

  assert_txctl_gra_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == 2'd2) |=> pendQ[GRA_BIT]);

  assert_unused_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == 2'd3 && evtSet == '0) |=> ($stable(pendQ) && $stable(maskQ)));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .evtSet    (evtSet),
  .pendQ     (pendQ),
  .maskQ     (maskQ),
  .irqOut    (irqOut)
);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  localparam int NL = 13;
  localparam int LB = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [NL-1:0] evtSet = '0;
  logic [NL-1:0] irqOut;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtSet(evtSet), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle starting at a negedge; returns at the next negedge
  task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d,
                     input logic [NL-1:0] ev);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; evtSet = ev;
    @(negedge clk);
    regWrEn = 1'b0; evtSet = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #2;
    v = regRdData;
  endtask

  function automatic logic [NL-1:0] lines(input logic [31:0] p, input logic [31:0] m);
    logic [31:0] x;
    x = (p & m) >> LB;
    return x[NL-1:0];
  endfunction

  initial begin
    #(20 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expPend;
    logic [31:0] expMask;
    expPend = '0; expMask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 pend", v, 32'h0);
    rd(2'd1, v); chk("R1 mask", v, 32'h0);
    chk("R1 irq", {19'd0, irqOut}, 32'h0);

    // R5 mask readback and low bits
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
    rd(2'd1, v); chk("R5 mask all ones", v, 32'hFFF8_0000);
    cyc(1'b1, 2'd1, 32'h0, '0);
    rd(2'd1, v); chk("R5 mask cleared", v, 32'h0);

    // R2/R6/R3 per-cause sweep
    for (int k = 0; k < NL; k++) begin
      cyc(1'b0, 2'd0, 32'h0, NL'(1) << k);
      rd(2'd0, v); chk($sformatf("R2 set line %0d", k), v, 32'h1 << (LB + k));
      @(negedge clk);
      chk($sformatf("R6 masked line %0d", k), {19'd0, irqOut}, 32'h0);
      cyc(1'b1, 2'd1, 32'h1 << (LB + k), '0);
      chk($sformatf("R6 latency line %0d", k), {19'd0, irqOut}, 32'h0);
      @(negedge clk);
      chk($sformatf("R6 open line %0d", k), {19'd0, irqOut}, 32'h1 << k);
      cyc(1'b1, 2'd0, ~(32'h1 << (LB + k)), '0);
      rd(2'd0, v); chk($sformatf("R3 zeros keep %0d", k), v, 32'h1 << (LB + k));
      cyc(1'b1, 2'd0, 32'h1 << (LB + k), '0);
      rd(2'd0, v); chk($sformatf("R3 clear %0d", k), v, 32'h0);
      @(negedge clk);
      chk($sformatf("R6 drop line %0d", k), {19'd0, irqOut}, 32'h0);
      cyc(1'b1, 2'd1, 32'h0, '0);
    end

    // R6 mask sweep over a fixed pending set
    cyc(1'b0, 2'd0, 32'h0, 13'h1ABC);
    expPend = 32'h1ABC << LB;
    for (int p = 0; p < 16; p++) begin
      expMask = (32'(p) * 32'h0001_3579) << LB;
      expMask = expMask & 32'hFFF8_0000;
      cyc(1'b1, 2'd1, expMask, '0);
      @(negedge clk);
      chk($sformatf("R6 sweep %0d", p), {19'd0, irqOut}, {19'd0, lines(expPend, expMask)});
    end

    // R4 set wins over simultaneous clear
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 13'h0004);
    rd(2'd0, v); chk("R4 set wins", v, 32'h1 << (LB + 2));
    cyc(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
    rd(2'd0, v); chk("R4 cleared after", v, 32'h0);

    // R7 transmit control raises graceful stop
    cyc(1'b1, 2'd2, 32'h0, '0);
    rd(2'd0, v); chk("R7 gra set", v, 32'h1000_0000);
    rd(2'd2, v); chk("R7 txctl reads zero", v, 32'h0);
    cyc(1'b1, 2'd1, 32'h1000_0000, '0);
    @(negedge clk);
    chk("R7 gra line", {19'd0, irqOut}, 32'h0000_0200);

    // R8 unused address
    cyc(1'b1, 2'd3, 32'hFFFF_FFFF, '0);
    rd(2'd3, v); chk("R8 reads zero", v, 32'h0);
    rd(2'd0, v); chk("R8 pend kept", v, 32'h1000_0000);
    rd(2'd1, v); chk("R8 mask kept", v, 32'h1000_0000);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule